// File: doc/BRIEF.md
# Serial Flash Command Front End

This block sits on the slave side of a single-line SPI flash. It watches the serial clock, the active-low select and the serial input, and runs all four pins through a synchronizer into the core clock domain. It decodes the first byte of each selected frame as an opcode. Register and identification opcodes are answered on the serial output, most significant bit first. The block holds the 8-bit status register. Two opcodes set and clear its write-enable latch. A status write needs the latch, and a set register-protect bit combined with a low write-protect pin blocks it. Any opcode the block does not know is dropped silently. An array controller next to the block reports through `array_busy` whether an erase or program is running. That level is shown as the progress bit, and its falling edge clears the write-enable latch.

The controller is one state machine with seven states. ST_IDLE is held while select is high. When select falls, the machine takes the transition to ST_OPCODE. When the eighth opcode bit arrives, it moves on to one of four states:
- ST_ARMED for the latch commands.
- ST_RESPOND for the status and identification reads.
- ST_DATA for a status write.
- ST_DUMMY for the two identification reads that are preceded by three don't-care bytes.

ST_DATA moves to ST_ARMED after its data byte. ST_DUMMY moves to ST_RESPOND after its third byte. A further clock edge in ST_ARMED moves the machine to ST_IGNORE, and so does an unknown opcode. The machine leaves ST_IGNORE only when select rises. A rise of select in ST_ARMED is the only point at which a command takes effect. From every state, a high select sends the machine back to ST_IDLE.

Top module: `spi_flash_cmd_front`

## Requirements
- R1: Input bits are sampled on rising SCK edges, MSB first, in both clock-idle-low and clock-idle-high framing. Response bits change only after a falling SCK edge, MSB first, and `so_oe` is high only during the response phase.
- R2: Opcode 06h sets status bit 1, the write-enable latch. Opcode 04h clears it.
- R3: Opcode 05h returns the status byte, and the byte repeats for as long as select stays low. The bit layout is:
  - bit 0 follows `array_busy`;
  - bit 1 is the latch;
  - bits 2 to 5 are the protect field, with its lowest bit at bit 2;
  - bit 6 always reads 0;
  - bit 7 is the register-protect bit.
- R4: Opcode 01h followed by one data byte loads bits 7 and 5:2 from that byte, and then clears the latch. Data bits 6, 1 and 0 have no effect. With the latch clear, the command changes nothing.
- R5: When bit 7 is set and `wp_n` is low, a status write is refused. The whole status byte stays as it was, including the latch.
- R6: A latch or status-write command acts only when select rises just after the eighth bit of its final byte. A rise inside a byte, a missing data byte, or any extra bit cancels it.
- R7: Opcode 9Fh returns 01h, then 40h, then the capacity code, and the three bytes repeat. The capacity code is 12h plus log2(size in Mbit), so 4, 8 and 16 Mbit give 14h, 15h and 16h.
- R8: Opcode 90h ignores three address bytes, then returns 01h followed by the device code, and the pair repeats. The device code is 10h plus log2(size in Mbit).
- R9: Opcode ABh ignores three bytes, then returns the device code, and it repeats.
- R10: Every opcode other than 01h, 04h, 05h, 06h, 90h, 9Fh and ABh is ignored. `so_oe` stays low and the status byte stays as it was. This covers the quad, suspend and second-status opcodes.
- R11: A falling edge on `array_busy` clears the write-enable latch.
- R12: After reset, the latch, the protect field and the register-protect bit are all 0, and `so_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, which oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write-protect pin |
| array_busy | input | 1 | High while the array controller runs an erase or program |
| so | output | 1 | Serial data out, 0 when not enabled |
| so_oe | output | 1 | Output enable for `so` |

## Verification
Assertions check four properties on every cycle:
- the latch rises only after a set request;
- the latch falls only after a clear request, an accepted write or a busy completion;
- the protected status fields hold still while the write-protect lock is active;
- the output enable opens only after a rising SCK edge, and the output bit moves only after a falling edge.

Only the bench's scenarios can show the rest:
- that the identification bytes appear in the right order and repeat;
- that truncated, overlong and unknown frames leave the status byte untouched;
- that the protect field keeps exactly the written bits.

The bench shows these by sweeping every opcode and many status-write values in both framings.

// File: rtl/spif_pkg.sv
package spif_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_DUMMY,
        ST_DATA,
        ST_RESPOND,
        ST_ARMED,
        ST_IGNORE
    } fsm_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WREN,
        CMD_WRDI,
        CMD_RDSR,
        CMD_WRSR,
        CMD_RDID,
        CMD_READID,
        CMD_RES
    } cmd_e;

    localparam logic [7:0] MFR_CODE = 8'h01;
    localparam logic [7:0] MEM_TYPE = 8'h40;

    function automatic cmd_e decode_op(input logic [7:0] op);
        case (op)
            8'h06:   return CMD_WREN;
            8'h04:   return CMD_WRDI;
            8'h05:   return CMD_RDSR;
            8'h01:   return CMD_WRSR;
            8'h9F:   return CMD_RDID;
            8'h90:   return CMD_READID;
            8'hAB:   return CMD_RES;
            default: return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spif_sync.sv
module spif_sync #(
    parameter int               WIDTH   = 5,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES <= 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= d;
            end
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] pipe;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= {STAGES{RST_VAL}};
                else        pipe <= {pipe[STAGES-2:0], d};
            end
            assign q = pipe[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spif_status.sv
module spif_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       wr_stat,
    input  logic [4:0] wr_fields,   // {protect-lock bit, protect field[3:0]}
    input  logic       wp_n,
    input  logic       busy,
    input  logic       busy_done,
    output logic [7:0] status
);

    logic       wel;
    logic       srp;
    logic [3:0] bp;
    logic       locked;
    logic       accept;

    assign locked = srp && !wp_n;
    assign accept = wr_stat && wel && !locked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel <= 1'b0;
            srp <= 1'b0;
            bp  <= 4'h0;
        end else if (accept) begin
            srp <= wr_fields[4];
            bp  <= wr_fields[3:0];
            wel <= 1'b0;
        end else if (set_wel) begin
            wel <= 1'b1;
        end else if (clr_wel || busy_done) begin
            wel <= 1'b0;
        end
    end

    assign status = {srp, 1'b0, bp, wel, busy};

    // R2: the latch only rises after a set request
    p_wel_set_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(set_wel));

    // R4, R11: the latch only falls after a clear, an accepted write or busy completion
    p_wel_clear_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wel) |-> $past(clr_wel || wr_stat || busy_done));

    // R5: locked register keeps its protection fields
    p_lock_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (srp && !wp_n) |=> $stable({srp, bp}));

endmodule

// File: rtl/spi_flash_cmd_front.sv
module spi_flash_cmd_front
    import spif_pkg::*;
#(
    parameter int DENSITY_MBIT = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic wp_n,
    input  logic array_busy,
    output logic so,
    output logic so_oe
);

    localparam int         LOG_MB      = $clog2(DENSITY_MBIT);
    localparam logic [7:0] DEV_ID      = 8'(16 + LOG_MB);
    localparam logic [7:0] CAP_ID      = 8'(18 + LOG_MB);
    localparam int         DUMMY_BYTES = 3;
    localparam int         NSYNC       = 5;

    // ---- pin synchronizer and edge detection
    logic [NSYNC-1:0] raw_pins;
    logic [NSYNC-1:0] sync_pins;
    logic sck_s, cs_s, si_s, wp_s, busy_s;
    logic sck_d, cs_d, busy_d;
    logic sck_rise, sck_fall, cs_rise, busy_fall;

    assign raw_pins = {array_busy, wp_n, si, cs_n, sck};

    spif_sync #(
        .WIDTH  (NSYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(5'b01010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_pins),
        .q    (sync_pins)
    );

    assign sck_s  = sync_pins[0];
    assign cs_s   = sync_pins[1];
    assign si_s   = sync_pins[2];
    assign wp_s   = sync_pins[3];
    assign busy_s = sync_pins[4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d  <= 1'b0;
            cs_d   <= 1'b1;
            busy_d <= 1'b0;
        end else begin
            sck_d  <= sck_s;
            cs_d   <= cs_s;
            busy_d <= busy_s;
        end
    end

    assign sck_rise  = sck_s & ~sck_d;
    assign sck_fall  = ~sck_s & sck_d;
    assign cs_rise   = cs_s & ~cs_d;
    assign busy_fall = ~busy_s & busy_d;

    // ---- control state
    fsm_e       state, state_nx;
    cmd_e       cmd_q, cmd_nx;
    logic [2:0] bit_cnt;
    logic [1:0] byte_idx;
    logic [1:0] dummy_cnt;
    logic [6:0] shift_in;
    logic [4:0] data_q;
    logic [7:0] in_byte;
    logic       byte_done;

    assign in_byte   = {shift_in, si_s};
    assign byte_done = sck_rise && (bit_cnt == 3'd7);

    // next-state logic
    always_comb begin
        state_nx = state;
        cmd_nx   = cmd_q;
        if (cs_s) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_OPCODE;
                ST_OPCODE: begin
                    if (byte_done) begin
                        cmd_nx = decode_op(in_byte);
                        case (cmd_nx)
                            CMD_WREN, CMD_WRDI:  state_nx = ST_ARMED;
                            CMD_RDSR, CMD_RDID:  state_nx = ST_RESPOND;
                            CMD_WRSR:            state_nx = ST_DATA;
                            CMD_READID, CMD_RES: state_nx = ST_DUMMY;
                            default:             state_nx = ST_IGNORE;
                        endcase
                    end
                end
                ST_DUMMY:   if (byte_done && dummy_cnt == 2'(DUMMY_BYTES - 1)) state_nx = ST_RESPOND;
                ST_DATA:    if (byte_done) state_nx = ST_ARMED;
                ST_ARMED:   if (sck_rise)  state_nx = ST_IGNORE;
                ST_RESPOND: state_nx = ST_RESPOND;
                ST_IGNORE:  state_nx = ST_IGNORE;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cmd_q     <= CMD_NONE;
            bit_cnt   <= 3'd0;
            byte_idx  <= 2'd0;
            dummy_cnt <= 2'd0;
            shift_in  <= 7'd0;
            data_q    <= 5'd0;
        end else begin
            state     <= state_nx;
            cmd_q     <= cmd_nx;
            bit_cnt   <= (state == ST_IDLE) ? 3'd0 : bit_cnt + 3'(sck_rise);
            dummy_cnt <= (state != ST_DUMMY) ? 2'd0 : dummy_cnt + 2'(byte_done);
            if (sck_rise) shift_in <= in_byte[6:0];
            if (state == ST_DATA && byte_done) data_q <= {in_byte[7], in_byte[5:2]};
            if (state != ST_RESPOND)  byte_idx <= 2'd0;
            else if (byte_done)       byte_idx <= (byte_idx == last_idx) ? 2'd0 : byte_idx + 2'd1;
        end
    end

    // ---- outputs
    logic [1:0] last_idx;
    logic [7:0] resp_byte;
    logic [7:0] status;
    logic       exec, set_wel, clr_wel, wr_stat;
    logic       so_q;

    always_comb begin
        last_idx  = 2'd0;
        resp_byte = 8'h00;
        unique case (cmd_q)
            CMD_RDSR:   resp_byte = status;
            CMD_RDID: begin
                last_idx = 2'd2;
                case (byte_idx)
                    2'd0:    resp_byte = MFR_CODE;
                    2'd1:    resp_byte = MEM_TYPE;
                    default: resp_byte = CAP_ID;
                endcase
            end
            CMD_READID: begin
                last_idx  = 2'd1;
                resp_byte = (byte_idx == 2'd0) ? MFR_CODE : DEV_ID;
            end
            CMD_RES:    resp_byte = DEV_ID;
            default:    resp_byte = 8'h00;
        endcase
    end

    assign exec    = cs_rise && (state == ST_ARMED);
    assign set_wel = exec && (cmd_q == CMD_WREN);
    assign clr_wel = exec && (cmd_q == CMD_WRDI);
    assign wr_stat = exec && (cmd_q == CMD_WRSR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   so_q <= 1'b0;
        else if (state != ST_RESPOND) so_q <= 1'b0;
        else if (sck_fall)            so_q <= resp_byte[3'd7 - bit_cnt];
    end

    assign so_oe = (state == ST_RESPOND) && !cs_s;
    assign so    = so_oe & so_q;

    spif_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_wel  (set_wel),
        .clr_wel  (clr_wel),
        .wr_stat  (wr_stat),
        .wr_fields(data_q),
        .wp_n     (wp_s),
        .busy     (busy_s),
        .busy_done(busy_fall),
        .status   (status)
    );

    // R1: the response phase only opens right after a sampling edge
    p_oe_after_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> $past(sck_rise));

    // R1: the driven bit only moves after a falling serial clock edge
    p_so_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && so != $past(so)) |-> $past(sck_fall));

endmodule

// File: tb/test_spi_flash_cmd_front.sv
`timescale 1ns/1ps
module test_spi_flash_cmd_front;

    localparam int MB   = 8;
    localparam int H    = 5;
    localparam int GAP  = 4;
    localparam logic [7:0] EXP_DEV = 8'(16 + $clog2(MB));
    localparam logic [7:0] EXP_CAP = 8'(18 + $clog2(MB));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic wp_n = 1'b1;
    logic array_busy = 1'b0;
    logic so, so_oe;
    bit   mode3 = 1'b0;

    int checks = 0;
    int errors = 0;

    logic       m_wel = 1'b0;
    logic       m_srp = 1'b0;
    logic [3:0] m_bp  = 4'h0;

    always #2 clk = ~clk;

    spi_flash_cmd_front #(.DENSITY_MBIT(MB)) i_spi_flash_cmd_front (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .wp_n(wp_n), .array_busy(array_busy), .so(so), .so_oe(so_oe)
    );

    function automatic logic [7:0] exp_status(input logic busy);
        return {m_srp, 1'b0, m_bp, m_wel, busy};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input int n, input logic [127:0] mosi,
                        output logic [127:0] miso, output bit oe_any);
        miso   = '0;
        oe_any = 1'b0;
        sck    = mode3;
        wait_clk(GAP);
        cs_n = 1'b0;
        wait_clk(GAP);
        for (int b = n - 1; b >= 0; b--) begin
            sck = 1'b0;
            si  = mosi[b];
            wait_clk(H);
            miso[b] = so;
            oe_any  = oe_any | so_oe;
            sck = 1'b1;
            wait_clk(H);
        end
        if (!mode3) begin
            sck = 1'b0;
            wait_clk(H);
        end
        cs_n = 1'b1;
        wait_clk(GAP);
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [127:0] r;
        bit oe;
        xfer(16, 128'h0500, r, oe);
        s = r[7:0];
    endtask

    task automatic cmd8(input logic [7:0] op);
        logic [127:0] r;
        bit oe;
        xfer(8, 128'(op), r, oe);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] r;
        logic [7:0]   s;
        logic [7:0]   d;
        bit           oe;

        wait_clk(6);
        rst_n = 1'b1;
        wait_clk(4);

        // R12: reset state
        check("R12 oe after reset", 128'(so_oe), 128'(0));
        rdsr(s);
        check("R12 status after reset", 128'(s), 128'(exp_status(1'b0)));

        // R2 / R1: latch set and clear, both framings
        cmd8(8'h06); m_wel = 1'b1;
        rdsr(s);
        check("R2 wren mode0", 128'(s), 128'(exp_status(1'b0)));
        mode3 = 1'b1;
        cmd8(8'h04); m_wel = 1'b0;
        rdsr(s);
        check("R2 wrdi mode3 R1", 128'(s), 128'(exp_status(1'b0)));
        mode3 = 1'b0;

        // R6: truncated and overlong latch commands
        xfer(7, 128'h03, r, oe);
        rdsr(s);
        check("R6 wren 7 bits", 128'(s), 128'(exp_status(1'b0)));
        xfer(9, 128'h00C, r, oe);
        rdsr(s);
        check("R6 wren 9 bits", 128'(s), 128'(exp_status(1'b0)));

        // R3: status repeats while selected
        cmd8(8'h06); m_wel = 1'b1;
        xfer(32, 128'h05000000, r, oe);
        check("R3 status repeat", r[23:0], 128'({3{exp_status(1'b0)}}));

        // R6 / R4: status write without its data byte, and with an extra byte
        cmd8(8'h01);
        rdsr(s);
        check("R6 wrsr no data", 128'(s), 128'(exp_status(1'b0)));
        xfer(24, 128'h01FCFF, r, oe);
        rdsr(s);
        check("R6 wrsr extra byte", 128'(s), 128'(exp_status(1'b0)));
        cmd8(8'h04); m_wel = 1'b0;

        // R4: status write sweep, with and without the latch
        for (int i = 0; i < 64; i++) begin
            mode3 = i[0];
            d = {i[4], i[5], i[3:0], i[5], ~i[0]};
            if ((i % 3) != 2) begin
                cmd8(8'h06);
                m_srp = d[7];
                m_bp  = d[5:2];
                m_wel = 1'b0;
            end
            xfer(16, 128'({8'h01, d}), r, oe);
            rdsr(s);
            check("R4 wrsr sweep", 128'(s), 128'(exp_status(1'b0)));
        end
        mode3 = 1'b0;

        // R5: write-protect lock
        cmd8(8'h06);
        xfer(16, 128'h0194, r, oe);
        m_srp = 1'b1; m_bp = 4'h5; m_wel = 1'b0;
        wp_n = 1'b0;
        cmd8(8'h06); m_wel = 1'b1;
        xfer(16, 128'h0100, r, oe);
        rdsr(s);
        check("R5 locked write refused", 128'(s), 128'(exp_status(1'b0)));
        wp_n = 1'b1;
        xfer(16, 128'h0100, r, oe);
        m_srp = 1'b0; m_bp = 4'h0; m_wel = 1'b0;
        rdsr(s);
        check("R5 unlocked write taken", 128'(s), 128'(exp_status(1'b0)));

        // R7: three-byte identification, mode 3
        mode3 = 1'b1;
        xfer(56, 128'(8'h9F) << 48, r, oe);
        check("R7 jedec id R1", r[47:0], 128'({8'h01, 8'h40, EXP_CAP, 8'h01, 8'h40, EXP_CAP}));
        mode3 = 1'b0;

        // R8: manufacturer and device after address
        xfer(64, 128'(8'h90) << 56, r, oe);
        check("R8 mfr dev", r[31:0], 128'({8'h01, EXP_DEV, 8'h01, EXP_DEV}));

        // R9: signature after dummy bytes
        xfer(48, 128'(8'hAB) << 40, r, oe);
        check("R9 signature", r[15:0], 128'({EXP_DEV, EXP_DEV}));

        // R11: busy reflected in bit 0, its completion clears the latch
        cmd8(8'h06); m_wel = 1'b1;
        array_busy = 1'b1;
        wait_clk(8);
        rdsr(s);
        check("R11 busy shown", 128'(s), 128'(exp_status(1'b1)));
        array_busy = 1'b0;
        wait_clk(8);
        m_wel = 1'b0;
        rdsr(s);
        check("R11 latch cleared", 128'(s), 128'(exp_status(1'b0)));

        // R10: every unknown opcode is dropped
        cmd8(8'h06); m_wel = 1'b1;
        for (int op = 0; op < 256; op++) begin
            if (op == 'h01 || op == 'h04 || op == 'h05 || op == 'h06 ||
                op == 'h90 || op == 'h9F || op == 'hAB) continue;
            mode3 = op[0];
            xfer(16, 128'({8'(op), 8'hFF}), r, oe);
            check("R10 no output", 128'(oe), 128'(0));
            rdsr(s);
            check("R10 status kept", 128'(s), 128'(exp_status(1'b0)));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule